// File: doc/BRIEF.md
# Packet Descriptor Ring Engine

This block holds the transmit and receive buffer descriptor tables of a packet MAC in internal storage. Software reaches the control registers and the descriptor table through one word-wide slave port. A count register splits the table into two rings: transmit entries first, receive entries after them. Ownership passes between software and the engine through one bit per entry: a transmit entry waits for its ready bit, and a receive entry is used only while its empty bit is set. The engine clears that bit when it writes the completion status back into the entry.

On the transmit side the engine walks its ring. For each ready entry it presents the buffer address, length and per-frame options to a data mover (`tx_req`). It waits for `tx_done` with a completion status, then writes that status back. On the receive side, a MAC-side pulse `rx_valid` reports a finished frame with its length and status. The engine stores both in the current receive entry when that entry is empty, and reports a busy event when it is not. The engine raises interrupt sources per entry, and software acknowledges them by writing ones.

The transmit controller has three states. T_IDLE moves to T_XFER (fetch) when the current entry is ready and the port is idle. T_XFER moves to T_WBACK (complete) on `tx_done`. T_WBACK moves back to T_IDLE (retire), writing the status and advancing the ring, once the port is idle. The receive controller has two states. R_IDLE moves to R_POST (capture) on `rx_valid`. R_POST moves back to R_IDLE (post) once the port is idle. Clearing a ring's enable bit forces its controller to its idle state.

Top module: `bd_ring_engine`

## Requirements
- R1: Register byte offsets are mode 0x00 (bit 0 receive enable, bit 1 transmit enable), interrupt source 0x04, interrupt mask 0x08 and transmit count 0x20. Entry i has its control/status word at 0x400+8i and its buffer address at 0x404+8i. After reset every register reads 0, and `irq`, `tx_req` and `rx_buf_avail` are low.
- R2: With transmit enabled and the transmit count non-zero, a current transmit entry whose bit 15 (ready) is set raises `tx_req`. While `tx_req` is high, `tx_addr` is the entry's address word, `tx_len` is bits 31:16, `tx_pad` is bit 12 and `tx_crc` is bit 11. `tx_req` and `tx_addr` hold until `tx_done`.
- R3: After `tx_done`, the entry's control word keeps bits 31:16 and 14:9, reads bit 15 as 0, and holds `tx_stat` in bits 8:0.
- R4: On transmit completion with bit 14 (interrupt enable) set, source bit 1 is set if `tx_stat` bit 0, 2, 3 or 8 is set, and source bit 0 is set otherwise. With bit 14 clear, no source bit is set.
- R5: The transmit ring starts at entry 0 and advances by one per completion. After an entry with bit 13 (wrap) set, or after entry count-1, it returns to entry 0. At an entry whose ready bit is clear it waits without requesting.
- R6: The receive ring starts at entry index equal to the transmit count. `rx_buf_addr` shows the current entry's address word, and `rx_buf_avail` is high when that entry's bit 15 (empty) is set. On `rx_valid` into an empty entry, the engine writes `rx_len` to bits 31:16 and `rx_stat` to bits 8:0, clears bit 15, keeps bits 14:9, and advances the ring (wrap bit 13 or the last table entry returns it to its first entry). When bit 14 is set it also raises one source bit: bit 6 if `rx_stat` bit 8 (control frame) is set, else bit 3 if any of `rx_stat` bits 0, 1, 2, 3, 5 or 6 is set, else bit 2.
- R7: `rx_valid` while the current receive entry is not empty sets source bit 4. It leaves the entry and the receive pointer unchanged.
- R8: Writing ones to the source register clears those bits, and bits written as zero are kept.
- R9: `irq` is high exactly when some source bit and the same mask bit are both set.
- R10: Clearing a ring's enable bit returns that ring to its first entry. While receive is disabled, `rx_valid` is ignored.
- R11: A write to the transmit count above the table size (128 entries by default) stores the table size.
- R12: Software access takes priority. The engine does not fetch, write back or post while `bus_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Slave access in this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| tx_req | output | 1 | Transmit buffer request to the data mover |
| tx_addr | output | 32 | Transmit buffer address |
| tx_len | output | 16 | Transmit length in bytes |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append FCS |
| tx_done | input | 1 | Transmit finished |
| tx_stat | input | 9 | Transmit completion status |
| rx_valid | input | 1 | Received frame complete (pulse) |
| rx_len | input | 16 | Received length including FCS |
| rx_stat | input | 9 | Receive status |
| rx_buf_addr | output | 32 | Buffer address of the current receive entry |
| rx_buf_avail | output | 1 | Current receive entry is empty |
| irq | output | 1 | Interrupt request |

## Verification
A wrong ring pointer shows up on the next request: `tx_addr` carries another entry's buffer address in the cycle `tx_req` rises, and `rx_buf_addr` changes at once. A wrong write-back shows up at the first read of the control word after completion, which is at most two cycles after `tx_done` or `rx_valid`. A wrong source or mask state appears on `irq` and on the source read in the same cycle. For this reason each step reads back the entry and the source register before the next stimulus.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
    localparam int LEN_W  = 16;
    localparam int STAT_W = 9;
    localparam int EV_W   = 7;

    // interrupt source positions
    localparam int EV_TX_OK   = 0;
    localparam int EV_TX_ERR  = 1;
    localparam int EV_RX_OK   = 2;
    localparam int EV_RX_ERR  = 3;
    localparam int EV_RX_BUSY = 4;
    localparam int EV_TX_CTL  = 5;
    localparam int EV_RX_CTL  = 6;

    // control bits of word 0, counted from bit 9 (field [14:9])
    localparam int C_IE   = 5;
    localparam int C_WRAP = 4;
    localparam int C_PAD  = 3;
    localparam int C_CRC  = 2;

    typedef enum logic [1:0] {T_IDLE, T_XFER, T_WBACK} tx_state_e;
    typedef enum logic       {R_IDLE, R_POST}          rx_state_e;
endpackage

// File: rtl/bdr_table.sv
module bdr_table #(
    parameter int NUM_BD = 128,
    parameter int IDX_W  = $clog2(NUM_BD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_act,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic             bus_word,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [IDX_W-1:0] tx_idx,
    output logic [31:0]      tx_w0,
    output logic [31:0]      tx_w1,
    input  logic             tx_we,
    input  logic [31:0]      tx_wdata,
    input  logic [IDX_W-1:0] rx_idx,
    output logic [31:0]      rx_w0,
    output logic [31:0]      rx_w1,
    input  logic             rx_we,
    input  logic [31:0]      rx_wdata
);
    logic [31:0] ctl_mem [NUM_BD];
    logic [31:0] adr_mem [NUM_BD];

    always_ff @(posedge clk) begin
        if (bus_we) begin
            if (bus_word) adr_mem[bus_idx] <= bus_wdata;
            else          ctl_mem[bus_idx] <= bus_wdata;
        end
        if (tx_we) ctl_mem[tx_idx] <= tx_wdata;
        if (rx_we) ctl_mem[rx_idx] <= rx_wdata;
    end

    assign bus_rdata = bus_word ? adr_mem[bus_idx] : ctl_mem[bus_idx];
    assign tx_w0 = ctl_mem[tx_idx];
    assign tx_w1 = adr_mem[tx_idx];
    assign rx_w0 = ctl_mem[rx_idx];
    assign rx_w1 = adr_mem[rx_idx];

    // R12: engine write-backs never share a cycle with a software access
    p_no_bus_clash_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_we || rx_we) |-> !bus_act);
endmodule

// File: rtl/bdr_regs.sv
module bdr_regs
    import bdr_pkg::*;
#(
    parameter int NUM_BD = 128,
    parameter int IDX_W  = $clog2(NUM_BD),
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       tbl_rdata,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_idx,
    output logic              tbl_word,
    input  logic [EV_W-1:0]   ev,
    output logic              rx_en,
    output logic              tx_en,
    output logic [IDX_W:0]    tx_cnt,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] OFS_MODE  = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] OFS_SRC   = ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] OFS_TXCNT = ADDR_W'('h20);
    localparam int                TBL_BASE  = 'h400;
    localparam int                TBL_END   = TBL_BASE + NUM_BD * 8;
    localparam logic [IDX_W:0]    CNT_MAX   = (IDX_W+1)'(NUM_BD);

    logic [1:0]        mode_q;
    logic [EV_W-1:0]   src_q, mask_q, clr;
    logic [IDX_W:0]    cnt_q;
    logic              tbl_hit, wr, src_wr;
    logic [ADDR_W-1:0] tbl_off;

    assign tbl_hit  = (32'(bus_addr) >= TBL_BASE) && (32'(bus_addr) < TBL_END);
    assign tbl_off  = bus_addr - ADDR_W'(TBL_BASE);
    assign tbl_idx  = tbl_off[IDX_W+2:3];
    assign tbl_word = tbl_off[2];
    assign wr       = bus_sel && bus_we;
    assign tbl_we   = wr && tbl_hit;
    assign src_wr   = wr && (bus_addr == OFS_SRC);
    assign clr      = src_wr ? bus_wdata[EV_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '0;
            src_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr && bus_addr == OFS_MODE) mode_q <= bus_wdata[1:0];
            if (wr && bus_addr == OFS_MASK) mask_q <= bus_wdata[EV_W-1:0];
            if (wr && bus_addr == OFS_TXCNT)
                cnt_q <= (bus_wdata > 32'(NUM_BD)) ? CNT_MAX : bus_wdata[IDX_W:0];
            src_q <= (src_q & ~clr) | ev;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (tbl_hit) bus_rdata = tbl_rdata;
        else begin
            case (bus_addr)
                OFS_MODE:  bus_rdata = 32'(mode_q);
                OFS_SRC:   bus_rdata = 32'(src_q);
                OFS_MASK:  bus_rdata = 32'(mask_q);
                OFS_TXCNT: bus_rdata = 32'(cnt_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign rx_en  = mode_q[0];
    assign tx_en  = mode_q[1];
    assign tx_cnt = cnt_q;
    assign irq    = |(src_q & mask_q);

    // R8: acknowledged bits are gone next cycle unless a new event sets them
    p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_wr && ((ev & bus_wdata[EV_W-1:0]) == '0))
        |=> ((src_q & $past(bus_wdata[EV_W-1:0])) == '0));

    // R9: the interrupt cannot rise without an event or a mask change
    p_irq_no_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0 && !(wr && bus_addr == OFS_MASK) && !irq) |=> !irq);
endmodule

// File: rtl/bdr_tx_fsm.sv
module bdr_tx_fsm
    import bdr_pkg::*;
#(
    parameter int NUM_BD = 128,
    parameter int IDX_W  = $clog2(NUM_BD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bus_busy,
    input  logic [IDX_W:0]    cnt,
    input  logic [31:9]       w0_hi,
    input  logic [31:0]       w1,
    input  logic              tx_done,
    input  logic [STAT_W-1:0] tx_stat,
    output logic [IDX_W-1:0]  idx,
    output logic              we,
    output logic [31:0]       wdata,
    output logic              tx_req,
    output logic [31:0]       tx_addr,
    output logic [LEN_W-1:0]  tx_len,
    output logic              tx_pad,
    output logic              tx_crc,
    output logic              ev_ok,
    output logic              ev_err
);
    tx_state_e         st_q, st_d;
    logic [IDX_W-1:0]  ptr_q;
    logic [LEN_W-1:0]  len_q;
    logic [5:0]        ctl_q;
    logic [31:0]       addr_q;
    logic [STAT_W-1:0] stat_q;
    logic              go, last, err;

    assign go   = (cnt != '0) && !bus_busy && w0_hi[15];
    assign last = ctl_q[C_WRAP] || ({1'b0, ptr_q} >= cnt - 1'b1);
    assign err  = stat_q[8] | stat_q[3] | stat_q[2] | stat_q[0];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            T_IDLE:  if (go)        st_d = T_XFER;
            T_XFER:  if (tx_done)   st_d = T_WBACK;
            T_WBACK: if (!bus_busy) st_d = T_IDLE;
            default:                st_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= T_IDLE;
            ptr_q  <= '0;
            len_q  <= '0;
            ctl_q  <= '0;
            addr_q <= '0;
            stat_q <= '0;
        end else if (!en) begin
            st_q  <= T_IDLE;
            ptr_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == T_IDLE && go) begin
                len_q  <= w0_hi[31:16];
                ctl_q  <= w0_hi[14:9];
                addr_q <= w1;
            end
            if (st_q == T_XFER && tx_done) stat_q <= tx_stat;
            if (we) ptr_q <= last ? '0 : ptr_q + 1'b1;
        end
    end

    always_comb begin
        idx     = ptr_q;
        tx_req  = (st_q == T_XFER);
        we      = (st_q == T_WBACK) && !bus_busy;
        wdata   = {len_q, 1'b0, ctl_q, stat_q};
        tx_addr = addr_q;
        tx_len  = len_q;
        tx_pad  = ctl_q[C_PAD];
        tx_crc  = ctl_q[C_CRC];
        ev_ok   = we && ctl_q[C_IE] && !err;
        ev_err  = we && ctl_q[C_IE] && err;
    end

    // R2: a request and its buffer address hold until the mover answers
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (tx_req && !tx_done) |=> (tx_req && $stable(tx_addr)));
endmodule

// File: rtl/bdr_rx_fsm.sv
module bdr_rx_fsm
    import bdr_pkg::*;
#(
    parameter int NUM_BD = 128,
    parameter int IDX_W  = $clog2(NUM_BD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bus_busy,
    input  logic [IDX_W:0]    cnt,
    input  logic [15:9]       ctl,
    input  logic [31:0]       w1,
    input  logic              rx_valid,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [STAT_W-1:0] rx_stat,
    output logic [IDX_W-1:0]  idx,
    output logic              we,
    output logic [31:0]       wdata,
    output logic [31:0]       buf_addr,
    output logic              buf_avail,
    output logic              ev_ok,
    output logic              ev_err,
    output logic              ev_busy,
    output logic              ev_ctl
);
    localparam logic [IDX_W:0] TBL_N = (IDX_W+1)'(NUM_BD);

    rx_state_e         st_q, st_d;
    logic [IDX_W-1:0]  rptr_q;
    logic [LEN_W-1:0]  len_q;
    logic [STAT_W-1:0] stat_q;
    logic [IDX_W:0]    ix_full;
    logic              has, own, last, post, rerr;

    assign ix_full = cnt + {1'b0, rptr_q};
    assign has     = ix_full < TBL_N;
    assign own     = ctl[15] && has;
    assign last    = ctl[9 + C_WRAP] || (ix_full >= TBL_N - 1'b1);
    assign post    = (st_q == R_POST) && !bus_busy;
    assign rerr    = |{stat_q[6:5], stat_q[3:0]};

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            R_IDLE:  if (rx_valid)  st_d = R_POST;
            R_POST:  if (!bus_busy) st_d = R_IDLE;
            default:                st_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= R_IDLE;
            rptr_q <= '0;
            len_q  <= '0;
            stat_q <= '0;
        end else if (!en) begin
            st_q   <= R_IDLE;
            rptr_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == R_IDLE && rx_valid) begin
                len_q  <= rx_len;
                stat_q <= rx_stat;
            end
            if (we) rptr_q <= last ? '0 : rptr_q + 1'b1;
        end
    end

    always_comb begin
        idx       = ix_full[IDX_W-1:0];
        we        = post && own;
        ev_busy   = post && !own;
        wdata     = {len_q, 1'b0, ctl[14:9], stat_q};
        buf_addr  = w1;
        buf_avail = en && own;
        ev_ctl    = we && ctl[9 + C_IE] && stat_q[8];
        ev_err    = we && ctl[9 + C_IE] && !stat_q[8] && rerr;
        ev_ok     = we && ctl[9 + C_IE] && !stat_q[8] && !rerr;
    end

    // R7: a frame that finds no empty entry does not move the ring
    p_busy_holds_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n || !en)
        ev_busy |=> $stable(rptr_q));
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
    import bdr_pkg::*;
#(
    parameter int NUM_BD = 128,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_req,
    output logic [31:0]       tx_addr,
    output logic [LEN_W-1:0]  tx_len,
    output logic              tx_pad,
    output logic              tx_crc,
    input  logic              tx_done,
    input  logic [STAT_W-1:0] tx_stat,
    input  logic              rx_valid,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [STAT_W-1:0] rx_stat,
    output logic [31:0]       rx_buf_addr,
    output logic              rx_buf_avail,
    output logic              irq
);
    localparam int IDX_W = $clog2(NUM_BD);

    logic [31:0]      tbl_rdata, tx_w0, tx_w1, rx_w0, rx_w1, tx_wdata, rx_wdata;
    logic             tbl_we, tbl_word, tx_we, rx_we, rx_en, tx_en;
    logic [IDX_W-1:0] tbl_idx, tx_idx, rx_idx;
    logic [IDX_W:0]   tx_cnt;
    logic [EV_W-1:0]  ev;
    logic             tx_ok, tx_err, rx_ok, rx_err, rx_busy, rx_ctl;

    assign ev = {rx_ctl, 1'b0, rx_busy, rx_err, rx_ok, tx_err, tx_ok};

    bdr_regs #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tbl_rdata(tbl_rdata), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_word(tbl_word),
        .ev(ev), .rx_en(rx_en), .tx_en(tx_en), .tx_cnt(tx_cnt), .irq(irq)
    );

    bdr_table #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst_n(rst_n), .bus_act(bus_sel), .bus_we(tbl_we),
        .bus_idx(tbl_idx), .bus_word(tbl_word), .bus_wdata(bus_wdata), .bus_rdata(tbl_rdata),
        .tx_idx(tx_idx), .tx_w0(tx_w0), .tx_w1(tx_w1), .tx_we(tx_we), .tx_wdata(tx_wdata),
        .rx_idx(rx_idx), .rx_w0(rx_w0), .rx_w1(rx_w1), .rx_we(rx_we), .rx_wdata(rx_wdata)
    );

    bdr_tx_fsm #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .bus_busy(bus_sel), .cnt(tx_cnt),
        .w0_hi(tx_w0[31:9]), .w1(tx_w1), .tx_done(tx_done), .tx_stat(tx_stat),
        .idx(tx_idx), .we(tx_we), .wdata(tx_wdata), .tx_req(tx_req), .tx_addr(tx_addr),
        .tx_len(tx_len), .tx_pad(tx_pad), .tx_crc(tx_crc), .ev_ok(tx_ok), .ev_err(tx_err)
    );

    bdr_rx_fsm #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .bus_busy(bus_sel), .cnt(tx_cnt),
        .ctl(rx_w0[15:9]), .w1(rx_w1), .rx_valid(rx_valid), .rx_len(rx_len), .rx_stat(rx_stat),
        .idx(rx_idx), .we(rx_we), .wdata(rx_wdata), .buf_addr(rx_buf_addr),
        .buf_avail(rx_buf_avail), .ev_ok(rx_ok), .ev_err(rx_err), .ev_busy(rx_busy),
        .ev_ctl(rx_ctl)
    );
endmodule

// File: tb/test_bd_ring_engine.sv
module test_bd_ring_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_req, tx_pad, tx_crc;
    logic [31:0] tx_addr;
    logic [15:0] tx_len;
    logic        tx_done = 1'b0;
    logic [8:0]  tx_stat = '0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_len = '0;
    logic [8:0]  rx_stat = '0;
    logic [31:0] rx_buf_addr;
    logic        rx_buf_avail, irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    bd_ring_engine i_bd_ring_engine (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_req(tx_req), .tx_addr(tx_addr),
        .tx_len(tx_len), .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done),
        .tx_stat(tx_stat), .rx_valid(rx_valid), .rx_len(rx_len), .rx_stat(rx_stat),
        .rx_buf_addr(rx_buf_addr), .rx_buf_avail(rx_buf_avail), .irq(irq)
    );

    // {entry[1:0], len[15:0], ie, wrap, stat[8:0], expected source[6:0]}
    localparam int NV = 5;
    localparam logic [35:0] TXV [NV] = '{
        {2'd0, 16'd64,   1'b1, 1'b0, 9'h000, 7'h01},
        {2'd1, 16'd100,  1'b1, 1'b0, 9'h004, 7'h02},
        {2'd2, 16'd1500, 1'b1, 1'b1, 9'h030, 7'h01},
        {2'd0, 16'd60,   1'b0, 1'b0, 9'h100, 7'h00},
        {2'd1, 16'd200,  1'b1, 1'b0, 9'h002, 7'h01}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_req(input string tag);
        for (int n = 0; n < 100 && !tx_req; n++) @(negedge clk);
        chk(tag, 32'(tx_req), 32'd1);
    endtask

    task automatic tx_finish(input logic [8:0] s);
        @(negedge clk);
        tx_done = 1'b1; tx_stat = s;
        @(negedge clk);
        tx_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [15:0] l, input logic [8:0] s);
        @(negedge clk);
        rx_valid = 1'b1; rx_len = l; rx_stat = s;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and register map
        bus_rd(12'h000, d); chk("R1 mode reset", d, 0);
        bus_rd(12'h004, d); chk("R1 source reset", d, 0);
        bus_rd(12'h008, d); chk("R1 mask reset", d, 0);
        bus_rd(12'h020, d); chk("R1 count reset", d, 0);
        chk("R1 irq reset", 32'(irq), 0);
        chk("R1 tx_req reset", 32'(tx_req), 0);
        chk("R1 rx_buf_avail reset", 32'(rx_buf_avail), 0);

        // R11 count cap
        bus_wr(12'h020, 32'd200);
        bus_rd(12'h020, d); chk("R11 count capped", d, 32'd128);
        bus_wr(12'h020, 32'd4);
        bus_rd(12'h020, d); chk("R11 count stored", d, 32'd4);
        bus_wr(12'h008, 32'h7F);
        bus_wr(12'h000, 32'h3);

        // table-driven transmit sequence: R2 R3 R4 R5 R8 R9
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  ix;
            logic [15:0] ln;
            logic        ie, wr;
            logic [8:0]  st;
            logic [6:0]  ex;
            logic [11:0] base;
            {ix, ln, ie, wr, st, ex} = TXV[v];
            base = 12'h400 + 12'(ix) * 12'd8;
            bus_wr(base + 12'd4, 32'h1000 + 32'(ix) * 32'h600);
            bus_wr(base, {ln, 1'b1, ie, wr, 1'b1, 1'b1, 2'b00, 9'h000});
            wait_req("R2 tx_req raised");
            chk("R5 tx_addr ring order", tx_addr, 32'h1000 + 32'(ix) * 32'h600);
            chk("R2 tx_len", 32'(tx_len), 32'(ln));
            chk("R2 tx_pad/tx_crc", {30'b0, tx_pad, tx_crc}, 32'd3);
            tx_finish(st);
            bus_rd(base, d);
            chk("R3 tx write-back", d, {ln, 1'b0, ie, wr, 1'b1, 1'b1, 2'b00, st});
            bus_rd(12'h004, d); chk("R4 tx source", d, 32'(ex));
            chk("R9 irq follows source", 32'(irq), 32'(ex != 0));
            bus_wr(12'h004, 32'h7F);
            bus_rd(12'h004, d); chk("R8 source cleared", d, 0);
        end

        // R5 entry 2 is not ready: no request
        repeat (10) @(negedge clk);
        chk("R5 waits on non-ready entry", 32'(tx_req), 0);

        // R10 disable resets transmit pointer; R12 software access stalls engine
        bus_wr(12'h000, 32'h1);
        bus_wr(12'h404, 32'h0000ABC0);
        bus_wr(12'h400, {16'd80, 16'h8000});
        bus_wr(12'h000, 32'h3);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 12'h000;
        repeat (5) @(negedge clk);
        chk("R12 no fetch during access", 32'(tx_req), 0);
        bus_sel = 1'b0;
        wait_req("R10 tx restarts");
        chk("R10 tx back at entry 0", tx_addr, 32'h0000ABC0);
        tx_finish(9'h000);
        bus_rd(12'h004, d); chk("R4 no source without enable bit", d, 0);

        // receive ring at entries 4 and 5
        bus_wr(12'h424, 32'h8000);
        bus_wr(12'h420, 32'h0000C000);
        bus_wr(12'h42C, 32'h9000);
        bus_wr(12'h428, 32'h0000E000);
        @(negedge clk);
        chk("R6 rx_buf_avail", 32'(rx_buf_avail), 1);
        chk("R6 rx_buf_addr at count", rx_buf_addr, 32'h8000);
        rx_frame(16'd68, 9'h000);
        bus_rd(12'h420, d); chk("R6 rx write-back", d, 32'h0044_4000);
        bus_rd(12'h004, d); chk("R6 rx frame source", d, 32'h04);
        bus_wr(12'h004, 32'h7F);
        chk("R6 rx_buf_addr advanced", rx_buf_addr, 32'h9000);
        rx_frame(16'd70, 9'h002);
        bus_rd(12'h428, d); chk("R6 rx error write-back", d, 32'h0046_6002);
        bus_rd(12'h004, d); chk("R6 rx error source", d, 32'h08);
        bus_wr(12'h004, 32'h7F);

        // R7 wrapped to entry 4, which is not empty
        @(negedge clk);
        chk("R7 rx_buf_avail low", 32'(rx_buf_avail), 0);
        chk("R6 rx wrap to first entry", rx_buf_addr, 32'h8000);
        rx_frame(16'd99, 9'h000);
        bus_rd(12'h004, d); chk("R7 busy source", d, 32'h10);
        bus_rd(12'h420, d); chk("R7 entry untouched", d, 32'h0044_4000);
        bus_wr(12'h004, 32'h7F);

        // R6 control frame into re-armed entry 4
        bus_wr(12'h420, 32'h0000C000);
        rx_frame(16'd64, 9'h100);
        bus_rd(12'h420, d); chk("R6 control write-back", d, 32'h0040_4100);
        bus_rd(12'h004, d); chk("R6 control source", d, 32'h40);

        // R9 masking
        bus_wr(12'h008, 32'h0);
        @(negedge clk); chk("R9 masked irq low", 32'(irq), 0);
        bus_wr(12'h008, 32'h40);
        @(negedge clk); chk("R9 unmasked irq high", 32'(irq), 1);
        bus_wr(12'h004, 32'h40);
        @(negedge clk); chk("R8 clear drops irq", 32'(irq), 0);
        bus_wr(12'h008, 32'h7F);

        // R10 receive disabled ignores frames, re-enable restarts at entry 4
        bus_wr(12'h000, 32'h2);
        bus_wr(12'h420, 32'h0000C000);
        rx_frame(16'd77, 9'h000);
        bus_rd(12'h004, d); chk("R10 rx ignored while off", d, 0);
        bus_rd(12'h420, d); chk("R10 entry kept while off", d, 32'h0000C000);
        bus_wr(12'h000, 32'h3);
        rx_frame(16'd90, 9'h000);
        bus_rd(12'h420, d); chk("R10 rx back at first entry", d, 32'h005A_4000);
        bus_rd(12'h004, d); chk("R10 rx source after restart", d, 32'h04);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule